// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces periodic DRAM refresh. An 8-bit up-counter advances on ticks from a prescaler, and a 3-bit select input picks the division ratio. On every tick the counter is compared with a programmable 8-bit constant. When the two are equal, the counter returns to zero and a match is reported. If refresh is enabled in CBR mode, the match issues a one-cycle refresh strobe and raises a pending request. The pending request stays high until the access sequencer acknowledges it.

In self-refresh mode no periodic requests are issued. Instead a level output asks the memory controller to keep the DRAM in self-refresh while refresh is enabled. With refresh disabled, the same counter and comparator act as a general 8-bit interval timer: they raise a sticky match flag that software clears. Software may load the counter at any time. A load, or any change of the clock select, restarts the prescaler phase, so the time to the next count is known exactly.

Top module: `refresh_timer`

## Requirements
- R1: After reset the count is 0 and cbr_strobe, cbr_pend, ovf_err, match_flag and self_req are all 0.
- R2: While clk_sel is 0 and no load is applied, the count does not change.
- R3: With clk_sel = k (1..7) the count advances once every 2^e cycles, with e = 2, 4, 6, 8, 10, 11, 12 for k = 1..7. The first advance lands exactly 2^e cycles after the edge that loaded the counter or changed clk_sel.
- R4: A cycle with cnt_wr = 1 loads cnt_wdata into the count at the next edge. A load takes priority over counting and suppresses any match in that cycle.
- R5: On a tick where the count equals cmp_val, the count becomes 0 instead of cmp_val+1. Starting from a loaded value w <= cmp_val, the first match therefore falls on tick cmp_val-w+1, and later matches fall every cmp_val+1 ticks.
- R6: match_flag goes to 1 on every match, in every mode. It stays 1 until flag_clr is applied. A match in the same cycle as flag_clr wins.
- R7: With rfsh_en = 1 and self_mode = 0, every match produces cbr_strobe high for exactly one cycle, on the same edge that zeroes the count, and sets cbr_pend.
- R8: cbr_pend stays 1 until a cycle with ack = 1 and no new match. That cycle clears it.
- R9: A refresh match while cbr_pend is 1 and ack is 0 sets ovf_err. ovf_err stays 1 until flag_clr.
- R10: With self_mode = 1, no cbr_strobe or cbr_pend is produced. self_req equals rfsh_en AND self_mode, registered one cycle late.
- R11: With rfsh_en = 0, matches still set match_flag but produce no cbr_strobe and no cbr_pend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_en | input | 1 | Refresh control enable |
| self_mode | input | 1 | 0 = CBR refresh, 1 = self-refresh |
| clk_sel | input | 3 | Prescaler select, 0 stops the counter |
| cnt_wr | input | 1 | Load strobe for the counter |
| cnt_wdata | input | 8 | Value loaded into the counter |
| cmp_val | input | 8 | Compare constant |
| flag_clr | input | 1 | Clears match_flag and ovf_err |
| ack | input | 1 | Refresh acknowledge from the access sequencer |
| count | output | 8 | Current counter value |
| cbr_strobe | output | 1 | One-cycle CBR refresh strobe |
| cbr_pend | output | 1 | CBR refresh pending until acknowledged |
| ovf_err | output | 1 | Sticky missed-refresh error |
| match_flag | output | 1 | Sticky compare-match flag |
| self_req | output | 1 | Self-refresh request level |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 12-bit prescaler that covers all seven ratios up to 4096. Small compare constants on the divide-by-4 setting make many matches happen in a few hundred cycles, so repeated refresh periods, back-to-back matches with a constant of zero, and missed acknowledges are all reachable quickly. Each of the slower ratios is checked once for its exact first-tick cycle, which takes at most 4096 cycles.

// File: rtl/rft_pkg.sv
package rft_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned PRE_W = 12;

  // Prescaler exponent for each clock-select code; 0 means stopped.
  function automatic int unsigned div_exp(input logic [SEL_W-1:0] s);
    case (s)
      3'd1: div_exp = 2;
      3'd2: div_exp = 4;
      3'd3: div_exp = 6;
      3'd4: div_exp = 8;
      3'd5: div_exp = 10;
      3'd6: div_exp = 11;
      3'd7: div_exp = 12;
      default: div_exp = 0;
    endcase
  endfunction
endpackage

// File: rtl/rft_prescaler.sv
module rft_prescaler
  import rft_pkg::*;
#(
  parameter int unsigned DIV_W = PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] mask;
  logic             restart;

  assign restart = load || (sel != sel_q);

  always_comb begin
    mask = '0;
    for (int i = 0; i < int'(DIV_W); i++) begin
      if (i < int'(div_exp(sel))) mask[i] = 1'b1;
    end
  end

  assign tick = (sel != '0) && !restart && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel;
      div_q <= restart ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/rft_counter.sv
module rft_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cmp,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  assign hit = tick && !wr && (count == cmp);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (wr)   count <= wdata;
    else if (hit)  count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/rft_reqctl.sv
module rft_reqctl (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic en,
  input  logic self_mode,
  input  logic ack,
  input  logic flag_clr,
  output logic strobe,
  output logic pend,
  output logic ovf,
  output logic flag,
  output logic self_req
);
  logic cbr_hit;
  assign cbr_hit = hit && en && !self_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe   <= 1'b0;
      pend     <= 1'b0;
      ovf      <= 1'b0;
      flag     <= 1'b0;
      self_req <= 1'b0;
    end else begin
      strobe   <= cbr_hit;
      self_req <= en && self_mode;
      if (cbr_hit)  pend <= 1'b1;
      else if (ack) pend <= 1'b0;
      if (cbr_hit && pend && !ack) ovf <= 1'b1;
      else if (flag_clr)           ovf <= 1'b0;
      if (hit)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rft_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rfsh_en,
  input  logic             self_mode,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             flag_clr,
  input  logic             ack,
  output logic [CNT_W-1:0] count,
  output logic             cbr_strobe,
  output logic             cbr_pend,
  output logic             ovf_err,
  output logic             match_flag,
  output logic             self_req
);
  logic tick;
  logic hit;

  rft_prescaler #(.DIV_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .load(cnt_wr), .sel(clk_sel), .tick(tick)
  );

  rft_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr(cnt_wr), .wdata(cnt_wdata), .cmp(cmp_val),
    .tick(tick), .count(count), .hit(hit)
  );

  rft_reqctl u_req (
    .clk(clk), .rst(rst), .hit(hit), .en(rfsh_en), .self_mode(self_mode),
    .ack(ack), .flag_clr(flag_clr), .strobe(cbr_strobe), .pend(cbr_pend),
    .ovf(ovf_err), .flag(match_flag), .self_req(self_req)
  );
endmodule

// File: rtl/rft_checker.sv
module rft_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rfsh_en,
  input logic             self_mode,
  input logic [2:0]       clk_sel,
  input logic             cnt_wr,
  input logic             flag_clr,
  input logic             ack,
  input logic [CNT_W-1:0] count,
  input logic             cbr_strobe,
  input logic             cbr_pend,
  input logic             ovf_err,
  input logic             match_flag,
  input logic             self_req
);
  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd0 && !cnt_wr) |=> $stable(count));

  assert_strobe_zeroes_count_R5: assert property (@(posedge clk) disable iff (rst)
    cbr_strobe |-> (count == '0));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (match_flag && !flag_clr) |=> match_flag);

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    cbr_strobe |=> !cbr_strobe);

  assert_strobe_pend_R7: assert property (@(posedge clk) disable iff (rst)
    cbr_strobe |-> (cbr_pend && match_flag));

  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cbr_pend && !ack) |=> cbr_pend);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf_err && !flag_clr) |=> ovf_err);

  assert_self_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    self_mode |=> !cbr_strobe);

  assert_self_level_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (self_req == $past(rfsh_en && self_mode)));

  assert_timer_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !rfsh_en |=> !cbr_strobe);
endmodule

bind refresh_timer rft_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rfsh_en(rfsh_en), .self_mode(self_mode),
  .clk_sel(clk_sel), .cnt_wr(cnt_wr), .flag_clr(flag_clr), .ack(ack),
  .count(count), .cbr_strobe(cbr_strobe), .cbr_pend(cbr_pend),
  .ovf_err(ovf_err), .match_flag(match_flag), .self_req(self_req)
);

// File: tb/sim_refresh_timer.sv
module sim_refresh_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rfsh_en = 1'b0, self_mode = 1'b0, cnt_wr = 1'b0;
  logic       flag_clr = 1'b0, ack = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic [7:0] cnt_wdata = 8'd0, cmp_val = 8'd0;
  logic [7:0] count;
  logic       cbr_strobe, cbr_pend, ovf_err, match_flag, self_req;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit auto_ack = 1'b0;
  bit done = 1'b0;

  refresh_timer u0 (
    .clk(clk), .rst(rst), .rfsh_en(rfsh_en), .self_mode(self_mode),
    .clk_sel(clk_sel), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_val(cmp_val), .flag_clr(flag_clr), .ack(ack), .count(count),
    .cbr_strobe(cbr_strobe), .cbr_pend(cbr_pend), .ovf_err(ovf_err),
    .match_flag(match_flag), .self_req(self_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: load counter and select in one cycle; returns the edge index.
  task automatic load(input logic [7:0] w, input logic [2:0] s, output int base);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = w; clk_sel = s;
    base = cyc + 1;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  // Push expected strobe cycles for divide-by-4: first after c-w+1 ticks.
  task automatic expect_strobes(input int base, input int w, input int c, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(base + 4*(c - w + 1) + 4*(c + 1)*i);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor: every strobe must match the head of the expectation queue.
  initial forever begin
    @(negedge clk);
    if (!rst && cbr_strobe) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected strobe", 1, 0);
      end else begin
        check("R7 strobe cycle", cyc, exp_q.pop_front());
        check("R5 count zero at match", count, 0);
      end
    end
  end

  // Acknowledge driver for the access sequencer side.
  initial forever begin
    @(negedge clk);
    ack = auto_ack && cbr_pend && !ack;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 strobe", cbr_strobe, 0);
    check("R1 pend", cbr_pend, 0);
    check("R1 ovf", ovf_err, 0);
    check("R1 flag", match_flag, 0);
    check("R1 self_req", self_req, 0);

    // R2/R4: load with select 0, counter holds
    load(8'd5, 3'd0, b);
    check("R4 load value", count, 5);
    repeat (40) @(negedge clk);
    check("R2 stopped count", count, 5);

    // R3: each ratio, exact first tick
    cmp_val = 8'd255;
    for (int k = 1; k <= 7; k++) begin
      int e;
      e = (k <= 5) ? 2*k : k + 5;
      load(8'd0, 3'(k), b);
      wait_until(b + (1 << e) - 1);
      check($sformatf("R3 sel%0d before tick", k), count, 0);
      @(negedge clk);
      check($sformatf("R3 sel%0d first tick", k), count, 1);
      wait_until(b + 2*(1 << e));
      check($sformatf("R3 sel%0d second tick", k), count, 2);
    end
    clk_sel = 3'd0;
    @(negedge clk);

    // R7/R8/R5: CBR refresh, w=1 c=3, acknowledged each time
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    rfsh_en = 1'b1; self_mode = 1'b0; cmp_val = 8'd3; auto_ack = 1'b1;
    load(8'd1, 3'd1, b);
    expect_strobes(b, 1, 3, 3);
    wait_until(b + 4*3 - 1);
    check("R5 count before first match", count, 3);
    check("R6 flag before match", match_flag, 0);
    wait_until(b + 4*3 + 32 + 1);
    clk_sel = 3'd0;
    repeat (3) @(negedge clk);
    check("R8 acked pend", cbr_pend, 0);
    check("R9 no overflow with ack", ovf_err, 0);
    check("R6 flag set", match_flag, 1);
    check("R7 strobes consumed", exp_q.size(), 0);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R6 flag cleared", match_flag, 0);

    // R9/R8: constant 0, no acknowledge, two matches
    auto_ack = 1'b0; cmp_val = 8'd0;
    load(8'd0, 3'd1, b);
    expect_strobes(b, 0, 0, 2);
    wait_until(b + 4);
    check("R8 pend raised", cbr_pend, 1);
    check("R9 no ovf on first", ovf_err, 0);
    wait_until(b + 8);
    clk_sel = 3'd0;
    @(negedge clk);
    check("R9 ovf on missed ack", ovf_err, 1);
    repeat (5) @(negedge clk);
    check("R8 pend held", cbr_pend, 1);
    check("R9 ovf held", ovf_err, 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R8 ack clears pend", cbr_pend, 0);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R9 ovf cleared", ovf_err, 0);
    check("R6 flag cleared again", match_flag, 0);

    // R10: self-refresh mode
    self_mode = 1'b1;
    @(negedge clk);
    check("R10 self_req high", self_req, 1);
    load(8'd0, 3'd1, b);
    repeat (20) @(negedge clk);
    check("R10 no pend", cbr_pend, 0);
    check("R6 flag in self mode", match_flag, 1);
    rfsh_en = 1'b0;
    @(negedge clk);
    check("R10 self_req follows enable", self_req, 0);
    clk_sel = 3'd0; self_mode = 1'b0;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

    // R11: timer use, refresh disabled, c=2
    cmp_val = 8'd2;
    load(8'd0, 3'd1, b);
    wait_until(b + 11);
    check("R11 flag before match", match_flag, 0);
    @(negedge clk);
    check("R11 flag at match", match_flag, 1);
    check("R5 count cleared in timer", count, 0);
    check("R11 no pend", cbr_pend, 0);
    clk_sel = 3'd0;
    repeat (4) @(negedge clk);
    check("R7 queue empty at end", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule